// File: doc/BRIEF.md
# Sized Logical-AND Execution Unit

This block takes one 16-bit logical-AND instruction word for a processor with eight 32-bit data registers and a five-bit condition-code register. It splits the word into its fields and checks the addressing mode against the direction of the operation. It flags every word that cannot be executed. For the register-to-register form it ANDs two data registers at byte, word or long size, writes the sized result back and updates the flags.

Memory forms are only decoded and checked for legality here. Operand fetch, address generation and traps belong to other units, so a legal memory form changes no state in this block.

The register file has a write port and a read port that the rest of the core uses. The write port loads a data register or the condition codes, and the read port lets the core observe a register. An execution strobe makes a decoded word take effect on the next rising clock edge.

Field layout of the instruction word:
- bits 15..12: the fixed pattern 1100
- bits 11..9: the data register
- bits 8..6: the op-mode (bit 8 is the direction, bits 7..6 are the size)
- bits 5..3: the addressing mode
- bits 2..0: the mode's register number

Top module: `and_exec_unit`

## Requirements
- R1: An active-high synchronous reset clears all eight data registers and all five condition-code bits to zero.
- R2: A word whose bits 15..12 are not 1100 raises `illegal` and, when strobed, changes no register and no flag.
- R3: Op-mode size bits 7..6 equal to 11 (op-mode 011 or 111) raise `illegal` in either direction.
- R4: Addressing mode 001 (address register direct) raises `illegal` in either direction.
- R5: With op-mode bit 8 set (the effective address is the destination), mode 000 is illegal. Mode 111 is legal only with register 000 or 001. Modes 010 through 110 are legal.
- R6: With op-mode bit 8 clear (the effective address is the source), modes 000 and 010 through 110 are legal. Mode 111 is legal with register 000 through 100 and illegal with 101 through 111.
- R7: A strobed legal word with bit 8 clear and mode 000 writes Dreg[11..9] AND Dreg[2..0] into data register bits 11..9. Size 00 replaces bits 7..0, size 01 replaces bits 15..0 and size 10 replaces all 32 bits. The remaining upper bits keep their value. `reg_exec` is high exactly for such words.
- R8: After an execution, N (ccr bit 3) equals bit 7, 15 or 31 of the AND for byte, word or long. Z (ccr bit 2) is set exactly when the sized AND is zero.
- R9: An execution clears V (ccr bit 1) and C (ccr bit 0) and leaves X (ccr bit 4) unchanged.
- R10: A legal memory form, or any word presented with the strobe low, changes no register and no flag.
- R11: The load port writes `ld_reg_data` into register `ld_reg_sel` and `ld_ccr_data` into the condition codes on the next edge. `rd_data` shows register `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Execution strobe for `insn_word` |
| insn_word | input | 16 | Instruction word |
| ld_reg_en | input | 1 | Data-register load enable |
| ld_reg_sel | input | 3 | Register to load |
| ld_reg_data | input | 32 | Load value |
| ld_ccr_en | input | 1 | Condition-code load enable |
| ld_ccr_data | input | 5 | Condition-code load value {X,N,Z,V,C} |
| rd_sel | input | 3 | Register selected for observation |
| rd_data | output | 32 | Contents of register `rd_sel` |
| ccr | output | 5 | Condition codes {X,N,Z,V,C} |
| illegal | output | 1 | Current word cannot be executed |
| reg_exec | output | 1 | Current word is a legal register-to-register AND |

## Verification
The assertions take for granted that the load port and the execution strobe are never active in the same cycle. The register-preservation properties assume that no other writer touches the registers while an execution is in flight. The bench keeps every load and every execution in separate cycles, each with a strobe of exactly one clock. It drives the full 16-bit word space with the strobe low, so that legality is swept without side effects.

// File: rtl/and_exec_pkg.sv
package and_exec_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NREGS   = 8;
  localparam int unsigned REG_W   = $clog2(NREGS);
  localparam int unsigned CCR_W   = 5;

  localparam int unsigned CC_X = 4;
  localparam int unsigned CC_N = 3;
  localparam int unsigned CC_Z = 2;
  localparam int unsigned CC_V = 1;
  localparam int unsigned CC_C = 0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } op_size_e;

  typedef enum logic [2:0] {
    AM_DREG  = 3'd0,
    AM_AREG  = 3'd1,
    AM_IND   = 3'd2,
    AM_POST  = 3'd3,
    AM_PRE   = 3'd4,
    AM_DISP  = 3'd5,
    AM_INDEX = 3'd6,
    AM_EXT   = 3'd7
  } addr_mode_e;

  typedef struct packed {
    logic [REG_W-1:0] dst_idx;
    logic             ea_is_dst;
    op_size_e         size;
    addr_mode_e       mode;
    logic [2:0]       ea_reg;
  } insn_fields_t;

  function automatic logic [DATA_W-1:0] size_mask(input op_size_e sz);
    logic [DATA_W-1:0] m;
    case (sz)
      SZ_BYTE: m = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_WORD: m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic sized_msb(input logic [DATA_W-1:0] v, input op_size_e sz);
    logic b;
    case (sz)
      SZ_BYTE: b = v[7];
      SZ_WORD: b = v[15];
      default: b = v[DATA_W-1];
    endcase
    return b;
  endfunction

  function automatic logic ext_reg_ok(input logic ea_is_dst, input logic [2:0] r);
    logic ok;
    if (ea_is_dst) ok = (r == 3'd0) || (r == 3'd1);
    else           ok = (r <= 3'd4);
    return ok;
  endfunction

endpackage

// File: rtl/and_decoder.sv
module and_decoder
  import and_exec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [15:0]  word,
  output insn_fields_t fields,
  output logic         illegal,
  output logic         reg_form
);

  logic nibble_ok;
  logic size_ok;
  logic mode_ok;

  always_comb begin
    fields.dst_idx   = word[11:9];
    fields.ea_is_dst = word[8];
    fields.size      = op_size_e'(word[7:6]);
    fields.mode      = addr_mode_e'(word[5:3]);
    fields.ea_reg    = word[2:0];
  end

  assign nibble_ok = (word[15:12] == 4'b1100);
  assign size_ok   = (fields.size != SZ_BAD);

  always_comb begin
    case (fields.mode)
      AM_DREG: mode_ok = !fields.ea_is_dst;
      AM_AREG: mode_ok = 1'b0;
      AM_EXT:  mode_ok = ext_reg_ok(fields.ea_is_dst, fields.ea_reg);
      default: mode_ok = 1'b1;
    endcase
  end

  assign illegal  = !(nibble_ok && size_ok && mode_ok);
  assign reg_form = !illegal && !fields.ea_is_dst && (fields.mode == AM_DREG);

  assert_bad_size_R3: assert property (@(posedge clk) disable iff (rst)
    (word[7:6] == 2'b11) |-> illegal);

  assert_areg_illegal_R4: assert property (@(posedge clk) disable iff (rst)
    (word[5:3] == 3'b001) |-> illegal);

  assert_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    (word[15:12] != 4'hC) |-> (illegal && !reg_form));

endmodule

// File: rtl/and_alu.sv
module and_alu
  import and_exec_pkg::*;
(
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  op_size_e          size,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] lane_mask,
  output logic              flag_n,
  output logic              flag_z
);

  logic [DATA_W-1:0] raw;

  assign raw       = dst_val & src_val;
  assign lane_mask = size_mask(size);
  assign result    = raw & lane_mask;
  assign flag_n    = sized_msb(raw, size);
  assign flag_z    = (result == '0);

endmodule

// File: rtl/and_regfile.sv
module and_regfile
  import and_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              ld_en,
  input  logic [REG_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [REG_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [REG_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic [REG_W-1:0]  rc_idx,
  output logic [DATA_W-1:0] rc_data
);

  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] old_word;

  assign old_word = regs[wr_idx];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == REG_W'(g))) begin
        regs[g] <= (regs[g] & ~wr_mask) | (wr_data & wr_mask);
      end else if (ld_en && (ld_idx == REG_W'(g))) begin
        regs[g] <= ld_data;
      end
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rc_data = regs[rc_idx];

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((regs[$past(wr_idx)] & ~$past(wr_mask)) == ($past(old_word) & ~$past(wr_mask))));

  assert_reset_regs_R1: assert property (@(posedge clk)
    rst |=> (regs[0] == '0 && regs[NREGS-1] == '0));

endmodule

// File: rtl/and_exec_unit.sv
module and_exec_unit
  import and_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [15:0]       insn_word,
  input  logic              ld_reg_en,
  input  logic [2:0]        ld_reg_sel,
  input  logic [31:0]       ld_reg_data,
  input  logic              ld_ccr_en,
  input  logic [4:0]        ld_ccr_data,
  input  logic [2:0]        rd_sel,
  output logic [31:0]       rd_data,
  output logic [4:0]        ccr,
  output logic              illegal,
  output logic              reg_exec
);

  insn_fields_t      f;
  logic              exec_fire;
  logic [DATA_W-1:0] dst_val;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] alu_mask;
  logic              alu_n;
  logic              alu_z;
  logic [CCR_W-1:0]  ccr_q;

  and_decoder u_dec (
    .clk      (clk),
    .rst      (rst),
    .word     (insn_word),
    .fields   (f),
    .illegal  (illegal),
    .reg_form (reg_exec)
  );

  assign exec_fire = insn_valid && reg_exec;

  and_regfile u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (exec_fire),
    .wr_idx  (f.dst_idx),
    .wr_data (alu_res),
    .wr_mask (alu_mask),
    .ld_en   (ld_reg_en),
    .ld_idx  (ld_reg_sel),
    .ld_data (ld_reg_data),
    .ra_idx  (f.dst_idx),
    .ra_data (dst_val),
    .rb_idx  (f.ea_reg),
    .rb_data (src_val),
    .rc_idx  (rd_sel),
    .rc_data (rd_data)
  );

  and_alu u_alu (
    .dst_val   (dst_val),
    .src_val   (src_val),
    .size      (f.size),
    .result    (alu_res),
    .lane_mask (alu_mask),
    .flag_n    (alu_n),
    .flag_z    (alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= '0;
    end else if (exec_fire) begin
      ccr_q[CC_N] <= alu_n;
      ccr_q[CC_Z] <= alu_z;
      ccr_q[CC_V] <= 1'b0;
      ccr_q[CC_C] <= 1'b0;
    end else if (ld_ccr_en) begin
      ccr_q <= ld_ccr_data;
    end
  end

  assign ccr = ccr_q;

  assert_vc_clear_x_kept_R9: assert property (@(posedge clk) disable iff (rst)
    exec_fire |=> (ccr_q[CC_V] == 1'b0 && ccr_q[CC_C] == 1'b0 && ccr_q[CC_X] == $past(ccr_q[CC_X])));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!exec_fire && !ld_ccr_en) |=> $stable(ccr_q));

  assert_reset_ccr_R1: assert property (@(posedge clk)
    rst |=> (ccr_q == '0));

endmodule

// File: tb/test_and_exec_unit.sv
module test_and_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_word = 16'h0;
  logic        ld_reg_en = 1'b0;
  logic [2:0]  ld_reg_sel = 3'd0;
  logic [31:0] ld_reg_data = 32'h0;
  logic        ld_ccr_en = 1'b0;
  logic [4:0]  ld_ccr_data = 5'd0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_data;
  logic [4:0]  ccr;
  logic        illegal;
  logic        reg_exec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  and_exec_unit i_and_exec_unit (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .ld_reg_en(ld_reg_en), .ld_reg_sel(ld_reg_sel), .ld_reg_data(ld_reg_data),
    .ld_ccr_en(ld_ccr_en), .ld_ccr_data(ld_ccr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .ccr(ccr), .illegal(illegal), .reg_exec(reg_exec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_reg(input int idx, input logic [31:0] v);
    @(negedge clk);
    ld_reg_en = 1'b1; ld_reg_sel = 3'(idx); ld_reg_data = v;
    @(negedge clk);
    ld_reg_en = 1'b0;
  endtask

  task automatic load_ccr(input logic [4:0] v);
    @(negedge clk);
    ld_ccr_en = 1'b1; ld_ccr_data = v;
    @(negedge clk);
    ld_ccr_en = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] w, input logic v);
    @(negedge clk);
    insn_word = w; insn_valid = v;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    rd_sel = 3'(idx);
    #1;
    v = rd_data;
  endtask

  function automatic logic model_legal(input logic [15:0] w);
    logic [7:0] mode_mask;
    logic [7:0] ext_mask;
    logic ok;
    mode_mask = w[8] ? 8'b0111_1100 : 8'b0111_1101;
    ext_mask  = w[8] ? 8'b0000_0011 : 8'b0001_1111;
    ok = (w[15:12] == 4'b1100) && (w[7:6] != 2'b11);
    if (w[5:3] == 3'd7) ok = ok && ext_mask[w[2:0]];
    else                ok = ok && mode_mask[w[5:3]];
    return ok;
  endfunction

  function automatic logic [15:0] rr_word(input int dx, input int sz, input int dy);
    return {4'b1100, 3'(dx), 1'b0, 2'(sz), 3'b000, 3'(dy)};
  endfunction

  logic [31:0] pats [8];
  logic [31:0] got;
  logic [31:0] lcg;

  initial begin
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'h8000_8080;
    pats[3] = 32'h7F7F_7F7F; pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h0000_FF00;
    pats[6] = 32'h1234_5678; pats[7] = 32'hFFFF_0000;

    // R1: load values, reset, expect zeros
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) load_reg(i, 32'hDEAD_0000 | 32'(i));
    load_ccr(5'b11111);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      read_reg(i, got);
      chk("R1 reg cleared", got, 32'h0);
    end
    chk("R1 ccr cleared", {27'd0, ccr}, 32'h0);

    // R11: load port and read port
    for (int i = 0; i < 8; i++) load_reg(i, pats[i] ^ 32'(i * 32'h0101_0101));
    for (int i = 0; i < 8; i++) begin
      read_reg(i, got);
      chk("R11 load/read", got, pats[i] ^ 32'(i * 32'h0101_0101));
    end
    load_ccr(5'b10101);
    chk("R11 ccr load", {27'd0, ccr}, {27'd0, 5'b10101});

    // R2 R3 R4 R5 R6: full legality sweep with strobe low
    for (int k = 0; k < 65536; k++) begin
      logic exp_ok;
      insn_word = 16'(k);
      #1;
      exp_ok = model_legal(16'(k));
      checks++;
      if (illegal !== !exp_ok) begin
        errors++;
        $display("FAIL R2/R3/R4/R5/R6 word %h: actual illegal=%b expected=%b", k[15:0], illegal, !exp_ok);
      end
      checks++;
      if (reg_exec !== (exp_ok && !insn_word[8] && insn_word[5:3] == 3'd0)) begin
        errors++;
        $display("FAIL R7 reg_exec word %h: actual=%b expected=%b", k[15:0], reg_exec,
                 exp_ok && !insn_word[8] && insn_word[5:3] == 3'd0);
      end
    end

    // R7 R8 R9: register-to-register executions over all sizes and pairs
    lcg = 32'h1357_9BDF;
    for (int sz = 0; sz < 3; sz++) begin
      for (int dx = 0; dx < 8; dx++) begin
        for (int dy = 0; dy < 8; dy++) begin
          logic [31:0] a, b, m, andv, expv, other;
          logic [4:0] c0;
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          a = pats[(dx + dy + sz) % 8] ^ (lcg & 32'h0F0F_F0F0);
          b = (dx == dy) ? a : pats[(dx * 3 + dy) % 8] | (lcg & 32'h0300_0003);
          load_reg(dx, a);
          if (dx != dy) load_reg(dy, b);
          c0 = 5'(lcg >> 7);
          load_ccr(c0);
          strobe(rr_word(dx, sz, dy), 1'b1);
          m = (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
          andv = a & b & m;
          expv = (a & ~m) | andv;
          read_reg(dx, got);
          chk("R7 sized write", got, expv);
          if (dx != dy) begin
            read_reg(dy, other);
            chk("R7 source kept", other, b);
          end
          chk("R8 N", {31'd0, ccr[3]}, {31'd0, andv[(sz == 0) ? 7 : (sz == 1) ? 15 : 31]});
          chk("R8 Z", {31'd0, ccr[2]}, {31'd0, andv == 32'h0});
          chk("R9 V C X", {27'd0, ccr[4], ccr[1:0]}, {29'd0, c0[4], 2'b00});
        end
      end
    end

    // R10 and R2: no state change for memory forms, idle strobe, illegal words
    begin
      logic [15:0] words [6];
      logic        vals  [6];
      words[0] = 16'hC210; vals[0] = 1'b1;  // (An) source, legal, memory
      words[1] = 16'hC3B9; vals[1] = 1'b1;  // EA dest abs.L, legal, memory
      words[2] = 16'hC201; vals[2] = 1'b0;  // reg form, strobe low
      words[3] = 16'h4201; vals[3] = 1'b1;  // wrong nibble
      words[4] = 16'hC2C1; vals[4] = 1'b1;  // size 11
      words[5] = 16'hC301; vals[5] = 1'b1;  // EA dest Dn, illegal
      for (int t = 0; t < 6; t++) begin
        for (int i = 0; i < 8; i++) load_reg(i, 32'hC0DE_0000 | 32'(i * 17 + t));
        load_ccr(5'b01010);
        strobe(words[t], vals[t]);
        for (int i = 0; i < 8; i++) begin
          read_reg(i, got);
          chk((t >= 3) ? "R2 no update" : "R10 no update", got, 32'hC0DE_0000 | 32'(i * 17 + t));
        end
        chk((t >= 3) ? "R2 flags kept" : "R10 flags kept", {27'd0, ccr}, {27'd0, 5'b01010});
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule